// File: doc/BRIEF.md
# Programmable DSP Address Modifier Unit

This block keeps the pointer registers of a DSP address generator. It advances one pointer on each access. The caller gives a 4-bit pointer index and a signed step. In the same cycle the block returns the address held before the change, and on the next clock edge it writes back the modified pointer.

The register file has eight low pointers, eight base registers, four modulus registers and eight high pointers. Each base register is paired with the low pointer of the same number. The high pointers have no storage of their own: each one is the base register with an index eight lower, seen under another name.

A 32-bit mode register holds one 4-bit field for each low pointer. That field picks how the pointer moves:
- plain two's-complement stepping;
- stepping with the carry running from the top bit downward;
- circular buffering between the paired base and base plus a chosen modulus;
- wrapping only inside an aligned power-of-two window.

The high pointers always step plainly. When a low pointer is not in a circular mode, its base register is not used for addressing and is free to act as an extra linear pointer.

Top module: `addr_mod_unit`

## Requirements
- R1: The mode register is 32 bits. It is written through `ctl_we`/`ctl_wdata` and read on `ctl_rdata`, with the new value visible one cycle after the write. It resets to zero. The field for low pointer n occupies bits 4n+3 down to 4n.
- R2: While `acc_req` is high, `acc_addr` shows the selected pointer's current value in the same cycle. The modified value is stored at the next rising clock edge.
- R3: Mode field 0000 (linear) stores pointer + step, with the step taken as two's complement and the result wrapping at AW bits.
- R4: Mode field 0001 (reverse-carry) stores rev(rev(pointer) + rev(step)), where rev mirrors the AW-bit word.
- R5: Mode field 10xx (modulo) uses modulus register Mxx and the paired base B. If pointer + step is at least B + M, M is subtracted. If it is below B, M is added. Otherwise the sum is stored.
- R6: Mode field 11xx (multiple wrap-around) uses modulus register Mxx, which is expected to be a power of two. The bits under M-1 become the low bits of pointer + step, and all higher bits of the pointer are kept.
- R7: Indices 8 to 15 always step linearly and ignore the mode register. High pointer k and base register k-8 are one storage element, so a write through either name is read back through both.
- R8: Mode fields 0010 to 0111 are reserved. An access to a low pointer with such a field steps linearly and sets `rsv_err`, which stays set until reset.
- R9: A register write and an access update that land on the same storage in the same cycle leave the written value. Writes to other storage in that cycle do not stop the update.
- R10: Register select codes used by `reg_sel` and `rd_sel`:
  - 0 to 7 select low pointers R0 to R7.
  - 8 to 15 select high pointers R8 to R15.
  - 16 to 23 select base registers B0 to B7.
  - 24 to 27 select modulus registers M0 to M3.
  - Reads of codes 28 to 31 return zero, and writes to them are ignored.
- R11: After reset every pointer, base and modulus register reads zero and `rsv_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Mode register write enable |
| ctl_wdata | input | 32 | Mode register write value |
| ctl_rdata | output | 32 | Mode register contents |
| reg_we | input | 1 | Register file write enable |
| reg_sel | input | 5 | Register file write select (R10 codes) |
| reg_wdata | input | AW | Register file write value |
| rd_sel | input | 5 | Register file read select (R10 codes) |
| rd_data | output | AW | Register file read value |
| acc_req | input | 1 | Single-cycle access request |
| acc_idx | input | 4 | Pointer index 0 to 15 |
| acc_step | input | AW | Signed step |
| acc_addr | output | AW | Pointer value before modification |
| rsv_err | output | 1 | Sticky reserved-mode flag |

## Verification
Linear mode is tried with positive and negative steps, which separates correct sign extension from zero extension. Reverse-carry is fed a top-bit step from zero, so that a carry running the wrong way gives a visibly different sequence. The circular mode is driven past both the upper and the lower bound, and the wrap-around mode is driven across a window edge in both directions, which shows whether the upper bits are kept. High-pointer aliasing, a reserved field, and writes colliding with updates on the same storage and on different storage each get their own scenario.

// File: rtl/addr_mod_unit.sv
module addr_mod_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic          reg_we,
  input  logic [4:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic [4:0]    rd_sel,
  output logic [AW-1:0] rd_data,
  input  logic          acc_req,
  input  logic [3:0]    acc_idx,
  input  logic [AW-1:0] acc_step,
  output logic [AW-1:0] acc_addr,
  output logic          rsv_err
);

  localparam int EW = AW + 2;

  logic [31:0]   ctl_q;
  logic [AW-1:0] ptr_q  [8];
  logic [AW-1:0] base_q [8];
  logic [AW-1:0] mod_q  [4];
  logic          err_q;

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] v);
    logic [AW-1:0] o;
    for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
    return o;
  endfunction

  logic          lo;
  logic [2:0]    slot;
  logic [3:0]    mode;
  logic          rsv;
  logic [AW-1:0] cur, base, msz, mask, lin, nxt;
  logic signed [EW-1:0] sum_e, top_e, bot_e;

  assign lo   = ~acc_idx[3];
  assign slot = acc_idx[2:0];
  assign mode = lo ? ctl_q[{slot, 2'b00} +: 4] : 4'b0000;
  assign rsv  = lo && !mode[3] && (mode[2:1] != 2'b00);
  assign cur  = lo ? ptr_q[slot] : base_q[slot];
  assign base = base_q[slot];
  assign msz  = mod_q[mode[1:0]];
  assign mask = msz - 1'b1;
  assign lin  = cur + acc_step;

  assign sum_e = $signed({2'b00, cur}) + $signed({{2{acc_step[AW-1]}}, acc_step});
  assign bot_e = $signed({2'b00, base});
  assign top_e = $signed({2'b00, base}) + $signed({2'b00, msz});

  always_comb begin
    nxt = lin;
    if (mode[3]) begin
      if (mode[2]) begin
        nxt = (cur & ~mask) | (lin & mask);
      end else if (sum_e >= top_e) begin
        nxt = sum_e[AW-1:0] - msz;
      end else if (sum_e < bot_e) begin
        nxt = sum_e[AW-1:0] + msz;
      end else begin
        nxt = sum_e[AW-1:0];
      end
    end else if (mode == 4'b0001) begin
      nxt = flip(flip(cur) + flip(acc_step));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= 1'b0;
      for (int i = 0; i < 8; i++) begin
        ptr_q[i]  <= '0;
        base_q[i] <= '0;
      end
      for (int i = 0; i < 4; i++) mod_q[i] <= '0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      if (acc_req) begin
        if (rsv) err_q <= 1'b1;
        if (lo) ptr_q[slot] <= nxt;
        else    base_q[slot] <= nxt;
      end
      if (reg_we) begin
        case (reg_sel[4:3])
          2'b00:   ptr_q[reg_sel[2:0]]  <= reg_wdata;
          2'b01,
          2'b10:   base_q[reg_sel[2:0]] <= reg_wdata;
          default: if (!reg_sel[2]) mod_q[reg_sel[1:0]] <= reg_wdata;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_sel[4:3])
      2'b00:   rd_data = ptr_q[rd_sel[2:0]];
      2'b01,
      2'b10:   rd_data = base_q[rd_sel[2:0]];
      default: rd_data = rd_sel[2] ? '0 : mod_q[rd_sel[1:0]];
    endcase
  end

  assign ctl_rdata = ctl_q;
  assign acc_addr  = cur;
  assign rsv_err   = err_q;

endmodule

// File: rtl/addr_mod_unit_chk.sv
module addr_mod_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [31:0]   ctl_wdata,
  input logic [31:0]   ctl_rdata,
  input logic          reg_we,
  input logic [4:0]    reg_sel,
  input logic [AW-1:0] reg_wdata,
  input logic [4:0]    rd_sel,
  input logic [AW-1:0] rd_data,
  input logic          acc_req,
  input logic [3:0]    acc_idx,
  input logic [AW-1:0] acc_step,
  input logic [AW-1:0] acc_addr,
  input logic          rsv_err
);

  // R1
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == $past(ctl_wdata));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_err |=> rsv_err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsv_err) |-> $past(acc_req));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel < 5'd28) |=>
      ((rd_sel != $past(reg_sel)) || (rd_data == $past(reg_wdata))));

  // R3 R7
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && $past(acc_req) && acc_idx == $past(acc_idx) && !$past(reg_we) &&
     ($past(acc_idx[3]) || ((($past(ctl_rdata) >> {acc_idx[2:0], 2'b00}) & 32'hF) == 32'h0)))
      |-> acc_addr == $past(acc_addr) + $past(acc_step));

endmodule

bind addr_mod_unit addr_mod_unit_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
  .acc_req(acc_req), .acc_idx(acc_idx), .acc_step(acc_step),
  .acc_addr(acc_addr), .rsv_err(rsv_err)
);

// File: tb/addr_mod_unit_tb_top.sv
module addr_mod_unit_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [31:0]   ctl_wdata = '0;
  logic [31:0]   ctl_rdata;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [4:0]    rd_sel = '0;
  logic [AW-1:0] rd_data;
  logic          acc_req = 1'b0;
  logic [3:0]    acc_idx = '0;
  logic [AW-1:0] acc_step = '0;
  logic [AW-1:0] acc_addr;
  logic          rsv_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_mod_unit #(.AW(AW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [AW-1:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wr_ctl(input logic [31:0] d);
    @(negedge clk); ctl_we = 1; ctl_wdata = d;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic rd(input logic [4:0] sel, output logic [AW-1:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic acc(input logic [3:0] idx, input logic [AW-1:0] st, output logic [AW-1:0] a);
    @(negedge clk); acc_req = 1; acc_idx = idx; acc_step = st;
    #1; a = acc_addr;
    @(negedge clk); acc_req = 0;
  endtask

  task automatic t_reset;
    logic [AW-1:0] v;
    chk("R11 ctl", ctl_rdata, 0);
    chk("R11 err", {31'b0, rsv_err}, 0);
    rd(5'd3, v);  chk("R11 R3", {16'b0, v}, 0);
    rd(5'd20, v); chk("R11 B4", {16'b0, v}, 0);
    rd(5'd26, v); chk("R11 M2", {16'b0, v}, 0);
  endtask

  task automatic t_ctl;
    wr_ctl(32'hA5C3_0F19);
    chk("R1 readback", ctl_rdata, 32'hA5C3_0F19);
    wr_ctl(32'h0);
    chk("R1 clear", ctl_rdata, 0);
  endtask

  task automatic t_linear;
    logic [AW-1:0] a, v;
    wr(5'd0, 16'd100);
    acc(4'd0, 16'd5, a);
    chk("R2 addr before update", {16'b0, a}, 100);
    rd(5'd0, v); chk("R3 positive step", {16'b0, v}, 105);
    acc(4'd0, -16'sd10, a);
    rd(5'd0, v); chk("R3 negative step", {16'b0, v}, 95);
  endtask

  task automatic t_reverse;
    logic [AW-1:0] a, v;
    wr_ctl(32'h0000_0010);
    wr(5'd1, 16'h0000);
    acc(4'd1, 16'h8000, a); rd(5'd1, v); chk("R4 rev step1", {16'b0, v}, 32'h8000);
    acc(4'd1, 16'h8000, a); rd(5'd1, v); chk("R4 rev step2", {16'b0, v}, 32'h4000);
    acc(4'd1, 16'h8000, a); rd(5'd1, v); chk("R4 rev step3", {16'b0, v}, 32'hC000);
  endtask

  task automatic t_modulo;
    logic [AW-1:0] a, v;
    wr_ctl(32'h0000_0900);
    wr(5'd25, 16'd10);
    wr(5'd18, 16'd200);
    wr(5'd2, 16'd207);
    acc(4'd2, 16'd4, a);
    chk("R2 modulo addr", {16'b0, a}, 207);
    rd(5'd2, v); chk("R5 upper wrap", {16'b0, v}, 201);
    acc(4'd2, -16'sd3, a);
    rd(5'd2, v); chk("R5 lower wrap", {16'b0, v}, 208);
    acc(4'd2, 16'd1, a);
    rd(5'd2, v); chk("R5 inside", {16'b0, v}, 209);
  endtask

  task automatic t_wrap;
    logic [AW-1:0] a, v;
    wr_ctl(32'h0000_E000);
    wr(5'd26, 16'd16);
    wr(5'd3, 16'h123E);
    acc(4'd3, 16'd3, a);
    rd(5'd3, v); chk("R6 wrap up", {16'b0, v}, 32'h1231);
    acc(4'd3, -16'sd2, a);
    rd(5'd3, v); chk("R6 wrap down", {16'b0, v}, 32'h123F);
  endtask

  task automatic t_high;
    logic [AW-1:0] a, v;
    wr_ctl(32'hFFFF_FFFF);
    wr(5'd16, 16'h0500);
    rd(5'd8, v); chk("R7 alias B0->R8", {16'b0, v}, 32'h0500);
    acc(4'd8, 16'd7, a);
    chk("R7 addr", {16'b0, a}, 32'h0500);
    rd(5'd16, v); chk("R7 linear in B0", {16'b0, v}, 32'h0507);
    wr(5'd15, 16'h0ABC);
    rd(5'd23, v); chk("R7 alias R15->B7", {16'b0, v}, 32'h0ABC);
    wr(5'd29, 16'hFFFF);
    rd(5'd29, v); chk("R10 unmapped", {16'b0, v}, 0);
    rd(5'd24, v); chk("R10 M0 untouched", {16'b0, v}, 0);
  endtask

  task automatic t_reserved;
    logic [AW-1:0] a, v;
    wr_ctl(32'h0000_0000);
    wr(5'd4, 16'd50);
    acc(4'd4, 16'd2, a);
    chk("R8 no error on linear", {31'b0, rsv_err}, 0);
    wr_ctl(32'h0003_0000);
    acc(4'd4, 16'd2, a);
    rd(5'd4, v); chk("R8 reserved linear", {16'b0, v}, 54);
    chk("R8 flag set", {31'b0, rsv_err}, 1);
    wr_ctl(32'h0);
    acc(4'd4, 16'd1, a);
    chk("R8 flag sticky", {31'b0, rsv_err}, 1);
  endtask

  task automatic t_priority;
    logic [AW-1:0] v;
    wr_ctl(32'h0);
    wr(5'd0, 16'd10);
    @(negedge clk);
    acc_req = 1; acc_idx = 4'd0; acc_step = 16'd1;
    reg_we = 1; reg_sel = 5'd0; reg_wdata = 16'h0777;
    @(negedge clk); acc_req = 0; reg_we = 0;
    rd(5'd0, v); chk("R9 write wins low", {16'b0, v}, 32'h0777);
    @(negedge clk);
    acc_req = 1; acc_idx = 4'd9; acc_step = 16'd1;
    reg_we = 1; reg_sel = 5'd17; reg_wdata = 16'h0333;
    @(negedge clk); acc_req = 0; reg_we = 0;
    rd(5'd9, v); chk("R9 write wins alias", {16'b0, v}, 32'h0333);
    @(negedge clk);
    acc_req = 1; acc_idx = 4'd0; acc_step = 16'd2;
    reg_we = 1; reg_sel = 5'd5; reg_wdata = 16'h0042;
    @(negedge clk); acc_req = 0; reg_we = 0;
    rd(5'd0, v); chk("R9 update kept", {16'b0, v}, 32'h0779);
    rd(5'd5, v); chk("R9 other write", {16'b0, v}, 32'h0042);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ctl;
    t_linear;
    t_reverse;
    t_modulo;
    t_wrap;
    t_high;
    t_reserved;
    t_priority;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule